// File: doc/BRIEF.md
# Eight-Channel Output Gate with Activity Watchdogs

This block sets the final on/off state of eight switched output channels. A command word committed by the serial front end is held in a local register and reaches the outputs in one of two ways. It is copied on a rising edge of the update strobe. It is also taken at once when a frame commits while the strobe is already high. Every enabled channel then passes through a set of force-off conditions: the global enable, supply health, a supply lockout, per-channel and chip-level over-temperature, and two activity watchdogs.

The two watchdogs are enabled separately. One expects a valid serial frame at least once per timeout window. The other expects the update strobe to stay high for a minimum run of cycles at least once per window, which catches a strobe that is stuck low. Both the window and the minimum high run are parameters counted in system-clock cycles. When either watchdog expires, all outputs turn off and a sticky status flag is raised for the status reporter. The flag clears only on an explicit read.

Top module: `drive_gate`

## Requirements
- R1: On a clock edge where `strobeIn` is high and was low at the previous edge, `cmdWord` is copied into the held command, and all eight channels change together. While `strobeIn` stays low, the held command does not change.
- R2: On a clock edge where `strobeIn` is high and `cmdValid` is high, `cmdWord` is copied into the held command. With `strobeIn` high and `cmdValid` low, nothing is copied.
- R3: While `enIn` is low, `chanOut` is 0 whatever the held command and strobe.
- R4: A channel whose `chanHot` bit is 1 has its `chanOut` bit at 0. While `chipHot` is 1, `chanOut` is 0.
- R5: While `supplyOk` is 0, `chanOut` is 0. After any edge that samples `supplyOk` low, and also after reset, `chanOut` stays 0 until an edge samples `mainGoodRise` high with `supplyOk` high.
- R6: With `spiWdOn` high, if no edge samples `cmdValid` high for `TIMEOUT_CYC` consecutive edges after the last one that did, `chanOut` is 0 from that edge onward. After `TIMEOUT_CYC - 1` such edges, the outputs are still driven.
- R7: With `strobeWdOn` high, a strobe high run counts as activity only once it lasts `MIN_HIGH_CYC` consecutive sampled cycles. Shorter high pulses do not keep the watchdog alive, and without activity `chanOut` goes to 0 after `TIMEOUT_CYC` edges.
- R8: An expired watchdog is cleared by its next activity event. The outputs then return to the held command without a new command being sent.
- R9: `wdFlag` goes to 1 on the edge after any watchdog expires. It stays 1 until an edge samples `statusRead` high while no watchdog is expired.
- R10: After reset, `chanOut` is 0, `wdFlag` is 0 and the held command is 0. A watchdog whose enable is low never expires, however long the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWord | input | NUM_CH | Committed channel command, bit i for channel i |
| cmdValid | input | 1 | One-cycle pulse: a valid frame committed `cmdWord` |
| strobeIn | input | 1 | Synchronized update strobe |
| enIn | input | 1 | Global enable, low forces all channels off |
| spiWdOn | input | 1 | Enables the frame-activity watchdog |
| strobeWdOn | input | 1 | Enables the strobe-activity watchdog |
| supplyOk | input | 1 | All supplies above their undervoltage thresholds |
| mainGoodRise | input | 1 | Main supply has crossed its good-rising threshold |
| chanHot | input | NUM_CH | Per-channel over-temperature flags |
| chipHot | input | 1 | Chip thermal shutdown |
| statusRead | input | 1 | Status word has been read out; clears `wdFlag` |
| chanOut | output | NUM_CH | Final channel on/off state |
| wdFlag | output | 1 | Sticky watchdog-expired status flag |

## Verification
The hardest state to reach is the exact edge at which the frame watchdog expires, because its counter is internal and only shows up as outputs dropping. The stimulus sends a run of frames well inside the window. It then lets exactly `TIMEOUT_CYC - 1` edges pass after the last frame and checks that the outputs are still on, and checks again one edge later that they are off. For the strobe watchdog, the bench feeds single-cycle strobe pulses, which rise often but never run long enough to count. It then switches to runs of the minimum length to show that those do keep the watchdog alive.

// File: rtl/drive_gate_pkg.sv
package drive_gate_pkg;
  localparam int NUM_WDOG  = 2;
  localparam int WD_FRAME  = 0;
  localparam int WD_STROBE = 1;

  typedef struct packed {
    logic loadCmd;
    logic allOff;
  } gateCtl_t;
endpackage

// File: rtl/drive_gate_wdog.sv
module drive_gate_wdog #(
  parameter int TIMEOUT_CYC = 120_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic kick,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || !enable || kick) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (cnt == CNT_LAST) begin
      expired <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/drive_gate_ctrl.sv
module drive_gate_ctrl
  import drive_gate_pkg::*;
#(
  parameter int TIMEOUT_CYC  = 120_000_000,
  parameter int MIN_HIGH_CYC = 100
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     strobeIn,
  input  logic     enIn,
  input  logic     spiWdOn,
  input  logic     strobeWdOn,
  input  logic     supplyOk,
  input  logic     mainGoodRise,
  input  logic     chipHot,
  input  logic     statusRead,
  output gateCtl_t ctl,
  output logic     wdFlag
);
  localparam int HW = $clog2(MIN_HIGH_CYC + 1);
  localparam logic [HW-1:0] HI_LAST = HW'(MIN_HIGH_CYC - 1);

  logic          strobePrev;
  logic [HW-1:0] hiCnt;
  logic          strobeEvent;
  logic          uvLock;
  logic [NUM_WDOG-1:0] wdEn, wdKick, wdExp;
  logic          anyExp;

  // strobe edge history and high-run length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      hiCnt      <= '0;
    end else begin
      strobePrev <= strobeIn;
      if (!strobeIn)             hiCnt <= '0;
      else if (hiCnt != HI_LAST) hiCnt <= hiCnt + 1'b1;
    end
  end

  assign strobeEvent = strobeIn && (hiCnt == HI_LAST);

  // supply lockout: set on any bad sample, cleared by good-rising flag
  always_ff @(posedge clk) begin
    if (!rstN)             uvLock <= 1'b1;
    else if (!supplyOk)    uvLock <= 1'b1;
    else if (mainGoodRise) uvLock <= 1'b0;
  end

  assign wdEn[WD_FRAME]    = spiWdOn;
  assign wdKick[WD_FRAME]  = cmdValid;
  assign wdEn[WD_STROBE]   = strobeWdOn;
  assign wdKick[WD_STROBE] = strobeEvent;

  for (genvar g = 0; g < NUM_WDOG; g++) begin : g_wdog
    drive_gate_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_wdog (
      .clk     (clk),
      .rstN    (rstN),
      .enable  (wdEn[g]),
      .kick    (wdKick[g]),
      .expired (wdExp[g])
    );
  end

  assign anyExp = |wdExp;

  always_ff @(posedge clk) begin
    if (!rstN)           wdFlag <= 1'b0;
    else if (anyExp)     wdFlag <= 1'b1;
    else if (statusRead) wdFlag <= 1'b0;
  end

  always_comb begin
    ctl.loadCmd = strobeIn && (!strobePrev || cmdValid);
    ctl.allOff  = !enIn || chipHot || !supplyOk || uvLock || anyExp;
  end
endmodule

// File: rtl/drive_gate_dp.sv
module drive_gate_dp
  import drive_gate_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmdWord,
  input  logic [NUM_CH-1:0] chanHot,
  input  gateCtl_t          ctl,
  output logic [NUM_CH-1:0] chanOut
);
  logic [NUM_CH-1:0] heldCmd;

  always_ff @(posedge clk) begin
    if (!rstN)            heldCmd <= '0;
    else if (ctl.loadCmd) heldCmd <= cmdWord;
  end

  assign chanOut = ctl.allOff ? '0 : (heldCmd & ~chanHot);
endmodule

// File: rtl/drive_gate.sv
module drive_gate
  import drive_gate_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int TIMEOUT_CYC  = 120_000_000,
  parameter int MIN_HIGH_CYC = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmdWord,
  input  logic              cmdValid,
  input  logic              strobeIn,
  input  logic              enIn,
  input  logic              spiWdOn,
  input  logic              strobeWdOn,
  input  logic              supplyOk,
  input  logic              mainGoodRise,
  input  logic [NUM_CH-1:0] chanHot,
  input  logic              chipHot,
  input  logic              statusRead,
  output logic [NUM_CH-1:0] chanOut,
  output logic              wdFlag
);
  gateCtl_t ctl;

  drive_gate_ctrl #(
    .TIMEOUT_CYC  (TIMEOUT_CYC),
    .MIN_HIGH_CYC (MIN_HIGH_CYC)
  ) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .strobeIn     (strobeIn),
    .enIn         (enIn),
    .spiWdOn      (spiWdOn),
    .strobeWdOn   (strobeWdOn),
    .supplyOk     (supplyOk),
    .mainGoodRise (mainGoodRise),
    .chipHot      (chipHot),
    .statusRead   (statusRead),
    .ctl          (ctl),
    .wdFlag       (wdFlag)
  );

  drive_gate_dp #(.NUM_CH(NUM_CH)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWord (cmdWord),
    .chanHot (chanHot),
    .ctl     (ctl),
    .chanOut (chanOut)
  );
endmodule

// File: rtl/drive_gate_chk.sv
module drive_gate_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enIn,
  input logic              chipHot,
  input logic [NUM_CH-1:0] chanHot,
  input logic              supplyOk,
  input logic              statusRead,
  input logic [NUM_CH-1:0] chanOut,
  input logic              wdFlag
);
  // R3
  enable_low_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |-> chanOut == '0);

  // R4
  chip_hot_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipHot |-> chanOut == '0);

  // R4
  chan_hot_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanOut & chanHot) == '0);

  // R5
  supply_bad_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> chanOut == '0);

  // R5
  supply_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!supplyOk) |-> chanOut == '0);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdFlag && !statusRead |=> wdFlag);
endmodule

bind drive_gate drive_gate_chk #(.NUM_CH(NUM_CH)) i_drive_gate_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enIn       (enIn),
  .chipHot    (chipHot),
  .chanHot    (chanHot),
  .supplyOk   (supplyOk),
  .statusRead (statusRead),
  .chanOut    (chanOut),
  .wdFlag     (wdFlag)
);

// File: tb/test_drive_gate.sv
module test_drive_gate;
  localparam int NCH = 8;
  localparam int TO  = 40;
  localparam int MH  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] cmdWord = '0;
  logic cmdValid = 1'b0, strobeIn = 1'b0, enIn = 1'b1;
  logic spiWdOn = 1'b0, strobeWdOn = 1'b0;
  logic supplyOk = 1'b1, mainGoodRise = 1'b0;
  logic [NCH-1:0] chanHot = '0;
  logic chipHot = 1'b0, statusRead = 1'b0;
  logic [NCH-1:0] chanOut;
  logic wdFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  drive_gate #(.NUM_CH(NCH), .TIMEOUT_CYC(TO), .MIN_HIGH_CYC(MH)) i_drive_gate (
    .clk(clk), .rstN(rstN), .cmdWord(cmdWord), .cmdValid(cmdValid),
    .strobeIn(strobeIn), .enIn(enIn), .spiWdOn(spiWdOn), .strobeWdOn(strobeWdOn),
    .supplyOk(supplyOk), .mainGoodRise(mainGoodRise), .chanHot(chanHot),
    .chipHot(chipHot), .statusRead(statusRead), .chanOut(chanOut), .wdFlag(wdFlag)
  );

  // {strobe, valid, en, chipHot, chanHot[7:0], cmd[7:0], expected[7:0]}
  localparam int NVEC = 11;
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hA5, 8'hFF},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'hA5, 8'hA5},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h3C, 8'h3C},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 8'h3C},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h0F, 8'h3C},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h0F, 8'h3C},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h0F, 8'h0F},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0F, 8'h00},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h03, 8'h0F, 8'h0C},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h0F, 8'h00},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h0F, 8'h0F}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    // reset state (R10)
    repeat (3) tick();
    chk("R10 reset out", chanOut, 8'h00);
    chk("R10 reset flag", {7'b0, wdFlag}, 8'h00);
    rstN = 1'b1;
    tick();
    // load under post-reset lockout (R5)
    strobeIn = 1'b1; cmdValid = 1'b1; cmdWord = 8'hFF;
    tick();
    chk("R5 lock after reset", chanOut, 8'h00);
    strobeIn = 1'b0; cmdValid = 1'b0; mainGoodRise = 1'b1;
    tick();
    mainGoodRise = 1'b0;
    chk("R5 good rise releases", chanOut, 8'hFF);

    // table walk (R1 R2 R3 R4)
    for (int i = 0; i < NVEC; i++) begin
      {strobeIn, cmdValid, enIn, chipHot, chanHot, cmdWord} = VEC[i][27:8];
      tick();
      chk($sformatf("table R1 R2 R3 R4 row %0d", i), chanOut, VEC[i][7:0]);
    end
    cmdValid = 1'b0;
    strobeIn = 1'b0;
    tick();

    // supply lockout (R5)
    supplyOk = 1'b0;
    tick();
    chk("R5 supply bad", chanOut, 8'h00);
    supplyOk = 1'b1;
    tick();
    tick();
    chk("R5 held off without good rise", chanOut, 8'h00);
    mainGoodRise = 1'b1;
    tick();
    mainGoodRise = 1'b0;
    chk("R5 resumes after good rise", chanOut, 8'h0F);

    // disabled watchdogs idle (R10, R1)
    repeat (100) tick();
    chk("R10 disabled wdog flag", {7'b0, wdFlag}, 8'h00);
    chk("R1 strobe low holds", chanOut, 8'h0F);

    // frame watchdog (R6)
    spiWdOn = 1'b1;
    for (int k = 0; k < 5; k++) begin
      repeat (15) tick();
      cmdValid = 1'b1;
      tick();
      cmdValid = 1'b0;
    end
    chk("R6 kept alive", chanOut, 8'h0F);
    chk("R6 no flag while alive", {7'b0, wdFlag}, 8'h00);
    repeat (TO - 1) tick();
    chk("R6 one edge before expiry", chanOut, 8'h0F);
    tick();
    chk("R6 expired", chanOut, 8'h00);
    tick();
    chk("R9 flag set", {7'b0, wdFlag}, 8'h01);
    cmdValid = 1'b1;
    tick();
    cmdValid = 1'b0;
    chk("R8 frame clears expiry", chanOut, 8'h0F);
    chk("R9 flag sticky", {7'b0, wdFlag}, 8'h01);
    statusRead = 1'b1;
    tick();
    statusRead = 1'b0;
    chk("R9 read clears flag", {7'b0, wdFlag}, 8'h00);
    spiWdOn = 1'b0;

    // strobe watchdog (R7)
    strobeWdOn = 1'b1;
    for (int k = 0; k < 10; k++) begin
      strobeIn = 1'b1;
      tick();
      strobeIn = 1'b0;
      repeat (7) tick();
    end
    chk("R7 short pulses expire", chanOut, 8'h00);
    chk("R7 flag set", {7'b0, wdFlag}, 8'h01);
    strobeIn = 1'b1;
    repeat (MH) tick();
    strobeIn = 1'b0;
    chk("R8 full high run clears", chanOut, 8'h0F);
    statusRead = 1'b1;
    tick();
    statusRead = 1'b0;
    for (int k = 0; k < 6; k++) begin
      strobeIn = 1'b1;
      repeat (MH) tick();
      strobeIn = 1'b0;
      repeat (15) tick();
    end
    chk("R7 full runs keep alive", chanOut, 8'h0F);
    chk("R7 no flag", {7'b0, wdFlag}, 8'h00);
    strobeWdOn = 1'b0;

    finishRun();
  end
endmodule